// File: doc/BRIEF.md
# Capability Bounds and Permission Checker

This block holds a small file of capability registers. Each register has a 128-bit token and a validity tag kept beside it. A token gives a current address, a base, a length and four permission bits. The block checks memory accesses made through these registers. The answer is deterministic: an access either passes or reports exactly one cause, and no guesswork is involved. When checks fail, the tag is examined first, then the permission, then the bounds, and the first failing rule is the cause reported.

A new capability can only come from an existing one, through the derive port. The result is written to a destination register and keeps its tag only when the request narrows or keeps the source's range and rights. The integer-write path stores raw data into a register and always clears its tag, so plain integers can never become capabilities.

After reset, register 0 holds a root capability that covers the whole 32-bit space with every right. All other registers start empty and invalid. A read port exposes any register and its tag.

Top module: `cap_guard`

## Requirements
- R1: Token layout: bits [31:0] hold the address, [63:32] the base, [95:64] the length, [99:96] the permissions (bit 96 read, 97 write, 98 execute, 99 seal), and [127:100] are reserved. A derived token has its reserved bits at zero.
- R2: After reset, register 0 holds base 0, length 32'hFFFF_FFFF, permissions 4'hF, address 0 and tag 1. Every other register is all zero with tag 0, and `res_valid` is 0.
- R3: An access request sampled on a clock edge produces `res_valid` high for exactly the cycle after that edge. No request means no result.
- R4: An access through a register whose tag is clear reports cause 1 (tag) and `res_ok` 0, whatever its fields hold.
- R5: Access kind 0/1/2/3 (read/write/execute/seal) needs permission bit 96/97/98/99. On a tagged register with that bit clear, the access reports cause 2 (permission).
- R6: A tagged, permitted access of size S at the token's address A reports cause 3 (bounds) unless base ≤ A and A+S ≤ base+length. Otherwise it reports cause 0 with `res_ok` 1. `res_ok` is 1 exactly when the cause is 0.
- R7: A derive request writes the requested address, base, length and permissions into the destination at the next edge. The tag is set when the source is tagged and the request is monotonic.
- R8: The derived tag is cleared when the source tag is clear, the new base is below the old base, the new top is above the old top, or a permission is requested that the source lacks.
- R9: An integer write stores its 128 bits verbatim with the tag cleared. When it targets the same register as a derive in the same cycle, the integer write wins.
- R10: Tops (base+length and address+size) are formed in 33 bits, so a range that runs past 2^32 never wraps into a pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access check request |
| acc_idx | input | IDXW | Register used for the access |
| acc_kind | input | 2 | 0 read, 1 write, 2 execute, 3 seal |
| acc_size | input | SZW | Access size in bytes |
| res_valid | output | 1 | Access result valid |
| res_ok | output | 1 | Access allowed |
| res_cause | output | 2 | 0 none, 1 tag, 2 permission, 3 bounds |
| drv_valid | input | 1 | Derive request |
| drv_src | input | IDXW | Source register |
| drv_dst | input | IDXW | Destination register |
| drv_addr | input | 32 | New current address |
| drv_base | input | 32 | New base |
| drv_len | input | 32 | New length |
| drv_perms | input | 4 | New permissions |
| iw_valid | input | 1 | Integer write request |
| iw_dst | input | IDXW | Register written |
| iw_data | input | 128 | Raw data written |
| rd_idx | input | IDXW | Register read |
| rd_data | output | 128 | Token of the register read |
| rd_tag | output | 1 | Tag of the register read |

## Verification
An access result is due one clock after the edge that samples the request. Derive and integer-write effects show on the combinational read port straight after the edge that captures them. The bench changes inputs just after a rising edge. Its driver pushes the expected cause into a queue when it issues an access, and the monitor pops that entry at the next falling edge, where `res_valid` must be high. Register contents are read back one short delay after the capturing edge, against a model built from the requirements.

// File: rtl/cap_pkg.sv
package cap_pkg;

    localparam int ADDR_W = 32;
    localparam int PERM_W = 4;
    localparam int RSVD_W = 128 - 3 * ADDR_W - PERM_W;

    typedef struct packed {
        logic [RSVD_W-1:0] rsvd;
        logic [PERM_W-1:0] perms;
        logic [ADDR_W-1:0] length;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] addr;
    } cap_t;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_SEAL  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        FAULT_NONE   = 2'd0,
        FAULT_TAG    = 2'd1,
        FAULT_PERM   = 2'd2,
        FAULT_BOUNDS = 2'd3
    } fault_e;

    localparam cap_t ROOT_CAP = '{
        rsvd:   '0,
        perms:  '1,
        length: '1,
        base:   '0,
        addr:   '0
    };

    function automatic logic [ADDR_W:0] cap_top(input cap_t c);
        return {1'b0, c.base} + {1'b0, c.length};
    endfunction

    function automatic logic [PERM_W-1:0] perm_mask(input acc_kind_e k);
        return PERM_W'(1) << k;
    endfunction

endpackage

// File: rtl/cap_regfile.sv
module cap_regfile
    import cap_pkg::*;
#(
    parameter int NREGS = 8,
    parameter int IDXW  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDXW-1:0]  ra_idx,
    output cap_t             ra_cap,
    output logic             ra_tag,
    input  logic [IDXW-1:0]  rb_idx,
    output cap_t             rb_cap,
    output logic             rb_tag,
    input  logic [IDXW-1:0]  rc_idx,
    output cap_t             rc_cap,
    output logic             rc_tag,
    input  logic             wa_en,
    input  logic [IDXW-1:0]  wa_idx,
    input  cap_t             wa_cap,
    input  logic             wa_tag,
    input  logic             wb_en,
    input  logic [IDXW-1:0]  wb_idx,
    input  logic [127:0]     wb_data,
    output logic [NREGS-1:0] tags_o
);

    cap_t             caps_q [NREGS];
    logic [NREGS-1:0] tag_q;

    for (genvar i = 0; i < NREGS; i++) begin : g_ent
        localparam cap_t RST_CAP = (i == 0) ? ROOT_CAP : cap_t'('0);
        localparam logic RST_TAG = (i == 0);

        always_ff @(posedge clk) begin
            if (rst) begin
                caps_q[i] <= RST_CAP;
                tag_q[i]  <= RST_TAG;
            end else if (wb_en && wb_idx == IDXW'(i)) begin
                caps_q[i] <= cap_t'(wb_data);
                tag_q[i]  <= 1'b0;
            end else if (wa_en && wa_idx == IDXW'(i)) begin
                caps_q[i] <= wa_cap;
                tag_q[i]  <= wa_tag;
            end
        end
    end

    assign ra_cap = caps_q[ra_idx];
    assign ra_tag = tag_q[ra_idx];
    assign rb_cap = caps_q[rb_idx];
    assign rb_tag = tag_q[rb_idx];
    assign rc_cap = caps_q[rc_idx];
    assign rc_tag = tag_q[rc_idx];
    assign tags_o = tag_q;

endmodule

// File: rtl/cap_access_check.sv
module cap_access_check
    import cap_pkg::*;
#(
    parameter int SZW = 8
) (
    input  cap_t            cap_i,
    input  logic            tag_i,
    input  acc_kind_e       kind_i,
    input  logic [SZW-1:0]  size_i,
    output fault_e          fault_o,
    output logic            pass_o
);

    logic [ADDR_W:0] top;
    logic [ADDR_W:0] end_addr;
    logic            perm_ok;
    logic            lo_ok;
    logic            hi_ok;
    logic            unused_rsvd;

    assign unused_rsvd = ^cap_i.rsvd;

    always_comb begin
        top      = cap_top(cap_i);
        end_addr = {1'b0, cap_i.addr} + (ADDR_W + 1)'(size_i);
        perm_ok  = |(cap_i.perms & perm_mask(kind_i));
        lo_ok    = cap_i.addr >= cap_i.base;
        hi_ok    = end_addr <= top;
        pass_o   = tag_i & perm_ok & lo_ok & hi_ok;

        if (!tag_i) begin
            fault_o = FAULT_TAG;
        end else if (!perm_ok) begin
            fault_o = FAULT_PERM;
        end else if (!(lo_ok && hi_ok)) begin
            fault_o = FAULT_BOUNDS;
        end else begin
            fault_o = FAULT_NONE;
        end
    end

endmodule

// File: rtl/cap_derive.sv
module cap_derive
    import cap_pkg::*;
(
    input  cap_t               src_cap,
    input  logic               src_tag,
    input  logic [ADDR_W-1:0]  new_addr,
    input  logic [ADDR_W-1:0]  new_base,
    input  logic [ADDR_W-1:0]  new_len,
    input  logic [PERM_W-1:0]  new_perms,
    output cap_t               res_cap,
    output logic               res_tag
);

    logic [ADDR_W:0] new_top;
    logic            base_ok;
    logic            top_ok;
    logic            perms_ok;
    logic            unused_src;

    assign unused_src = ^{src_cap.rsvd, src_cap.addr};

    always_comb begin
        new_top  = {1'b0, new_base} + {1'b0, new_len};
        base_ok  = new_base >= src_cap.base;
        top_ok   = new_top <= cap_top(src_cap);
        perms_ok = (new_perms & ~src_cap.perms) == '0;
        res_tag  = src_tag & base_ok & top_ok & perms_ok;
        res_cap  = '{
            rsvd:   '0,
            perms:  new_perms,
            length: new_len,
            base:   new_base,
            addr:   new_addr
        };
    end

endmodule

// File: rtl/cap_guard.sv
module cap_guard
    import cap_pkg::*;
#(
    parameter int NREGS = 8,
    parameter int SZW   = 8,
    localparam int IDXW = (NREGS > 1) ? $clog2(NREGS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_valid,
    input  logic [IDXW-1:0]  acc_idx,
    input  logic [1:0]       acc_kind,
    input  logic [SZW-1:0]   acc_size,
    output logic             res_valid,
    output logic             res_ok,
    output logic [1:0]       res_cause,
    input  logic             drv_valid,
    input  logic [IDXW-1:0]  drv_src,
    input  logic [IDXW-1:0]  drv_dst,
    input  logic [31:0]      drv_addr,
    input  logic [31:0]      drv_base,
    input  logic [31:0]      drv_len,
    input  logic [3:0]       drv_perms,
    input  logic             iw_valid,
    input  logic [IDXW-1:0]  iw_dst,
    input  logic [127:0]     iw_data,
    input  logic [IDXW-1:0]  rd_idx,
    output logic [127:0]     rd_data,
    output logic             rd_tag
);

    cap_t             acc_cap;
    logic             acc_tag;
    cap_t             src_cap;
    logic             src_tag;
    cap_t             drv_cap;
    logic             drv_tag;
    cap_t             rd_cap;
    logic [NREGS-1:0] tags_q;
    fault_e           fault;
    logic             pass;
    fault_e           cause_q;

    cap_regfile #(
        .NREGS (NREGS),
        .IDXW  (IDXW)
    ) u_rf (
        .clk     (clk),
        .rst     (rst),
        .ra_idx  (acc_idx),
        .ra_cap  (acc_cap),
        .ra_tag  (acc_tag),
        .rb_idx  (drv_src),
        .rb_cap  (src_cap),
        .rb_tag  (src_tag),
        .rc_idx  (rd_idx),
        .rc_cap  (rd_cap),
        .rc_tag  (rd_tag),
        .wa_en   (drv_valid),
        .wa_idx  (drv_dst),
        .wa_cap  (drv_cap),
        .wa_tag  (drv_tag),
        .wb_en   (iw_valid),
        .wb_idx  (iw_dst),
        .wb_data (iw_data),
        .tags_o  (tags_q)
    );

    cap_access_check #(
        .SZW (SZW)
    ) u_chk (
        .cap_i   (acc_cap),
        .tag_i   (acc_tag),
        .kind_i  (acc_kind_e'(acc_kind)),
        .size_i  (acc_size),
        .fault_o (fault),
        .pass_o  (pass)
    );

    cap_derive u_drv (
        .src_cap   (src_cap),
        .src_tag   (src_tag),
        .new_addr  (drv_addr),
        .new_base  (drv_base),
        .new_len   (drv_len),
        .new_perms (drv_perms),
        .res_cap   (drv_cap),
        .res_tag   (drv_tag)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_ok    <= 1'b0;
            cause_q   <= FAULT_NONE;
        end else begin
            res_valid <= acc_valid;
            if (acc_valid) begin
                res_ok  <= pass;
                cause_q <= fault;
            end
        end
    end

    assign res_cause = cause_q;
    assign rd_data   = rd_cap;

endmodule

// File: rtl/cap_guard_checker.sv
module cap_guard_checker #(
    parameter int NREGS = 8,
    parameter int IDXW  = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             acc_valid,
    input logic [IDXW-1:0]  acc_idx,
    input logic             res_valid,
    input logic             res_ok,
    input logic [1:0]       res_cause,
    input logic             drv_valid,
    input logic [IDXW-1:0]  drv_src,
    input logic [IDXW-1:0]  drv_dst,
    input logic             iw_valid,
    input logic [IDXW-1:0]  iw_dst,
    input logic [NREGS-1:0] tags
);

    p_res_follows_req_r3: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> res_valid);

    p_no_spurious_res_r3: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> !res_valid);

    p_untagged_fault_r4: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !tags[acc_idx]) |=> (res_cause == 2'd1 && !res_ok));

    p_ok_matches_cause_r6: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_ok == (res_cause == 2'd0)));

    p_no_forge_r8: assert property (@(posedge clk) disable iff (rst)
        (drv_valid && !tags[drv_src]) |=> !tags[$past(drv_dst)]);

    p_intw_strips_r9: assert property (@(posedge clk) disable iff (rst)
        iw_valid |=> !tags[$past(iw_dst)]);

endmodule

bind cap_guard cap_guard_checker #(
    .NREGS (NREGS),
    .IDXW  (IDXW)
) u_guard_chk (
    .clk       (clk),
    .rst       (rst),
    .acc_valid (acc_valid),
    .acc_idx   (acc_idx),
    .res_valid (res_valid),
    .res_ok    (res_ok),
    .res_cause (res_cause),
    .drv_valid (drv_valid),
    .drv_src   (drv_src),
    .drv_dst   (drv_dst),
    .iw_valid  (iw_valid),
    .iw_dst    (iw_dst),
    .tags      (tags_q)
);

// File: tb/cap_guard_test.sv
module cap_guard_test;

    localparam int NREGS = 8;
    localparam int SZW   = 8;
    localparam int IDXW  = 3;

    typedef struct {
        int    cause;
        string req;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             acc_valid = 1'b0;
    logic [IDXW-1:0]  acc_idx = '0;
    logic [1:0]       acc_kind = '0;
    logic [SZW-1:0]   acc_size = '0;
    logic             res_valid;
    logic             res_ok;
    logic [1:0]       res_cause;
    logic             drv_valid = 1'b0;
    logic [IDXW-1:0]  drv_src = '0;
    logic [IDXW-1:0]  drv_dst = '0;
    logic [31:0]      drv_addr = '0;
    logic [31:0]      drv_base = '0;
    logic [31:0]      drv_len = '0;
    logic [3:0]       drv_perms = '0;
    logic             iw_valid = 1'b0;
    logic [IDXW-1:0]  iw_dst = '0;
    logic [127:0]     iw_data = '0;
    logic [IDXW-1:0]  rd_idx = '0;
    logic [127:0]     rd_data;
    logic             rd_tag;

    int   n_checks = 0;
    int   n_fail   = 0;
    bit   finished = 1'b0;
    exp_t exp_q[$];

    logic [127:0] m_cap [NREGS];
    logic         m_tag [NREGS];

    always #10ns clk = ~clk;

    cap_guard #(.NREGS(NREGS), .SZW(SZW)) uut (.*);

    function automatic logic [127:0] mk(logic [31:0] a, logic [31:0] b,
                                        logic [31:0] l, logic [3:0] p);
        return {28'd0, p, l, b, a};
    endfunction

    task automatic check(bit ok, string req, string what,
                         logic [127:0] act, logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_reg(int idx, string req);
        rd_idx = IDXW'(idx);
        #1ns;
        check(rd_data == m_cap[idx] && rd_tag == m_tag[idx], req,
              $sformatf("reg %0d", idx), {rd_tag, rd_data[126:0]},
              {m_tag[idx], m_cap[idx][126:0]});
        check(rd_data[127] == m_cap[idx][127], req, "reg top bit",
              128'(rd_data[127]), 128'(m_cap[idx][127]));
    endtask

    task automatic do_access(int idx, int kind, int size, string req);
        logic [127:0] c;
        logic [32:0]  top, fin;
        exp_t         e;
        c   = m_cap[idx];
        top = {1'b0, c[63:32]} + {1'b0, c[95:64]};
        fin = {1'b0, c[31:0]} + 33'(size);
        if (!m_tag[idx])                         e.cause = 1;
        else if (!c[96 + kind])                  e.cause = 2;
        else if (c[31:0] < c[63:32] || fin > top) e.cause = 3;
        else                                     e.cause = 0;
        e.req = req;
        exp_q.push_back(e);
        acc_idx   = IDXW'(idx);
        acc_kind  = 2'(kind);
        acc_size  = SZW'(size);
        acc_valid = 1'b1;
        @(posedge clk);
        #1ns;
        acc_valid = 1'b0;
    endtask

    task automatic do_derive(int src, int dst, logic [31:0] a, logic [31:0] b,
                             logic [31:0] l, logic [3:0] p, string req);
        logic [127:0] s;
        logic [32:0]  otop, ntop;
        bit           t;
        s    = m_cap[src];
        otop = {1'b0, s[63:32]} + {1'b0, s[95:64]};
        ntop = {1'b0, b} + {1'b0, l};
        t    = m_tag[src] && b >= s[63:32] && ntop <= otop && (p & ~s[99:96]) == 4'd0;
        drv_src = IDXW'(src); drv_dst = IDXW'(dst);
        drv_addr = a; drv_base = b; drv_len = l; drv_perms = p;
        drv_valid = 1'b1;
        @(posedge clk);
        #1ns;
        drv_valid = 1'b0;
        m_cap[dst] = mk(a, b, l, p);
        m_tag[dst] = t;
        check_reg(dst, req);
    endtask

    task automatic do_intw(int dst, logic [127:0] d, string req);
        iw_dst = IDXW'(dst); iw_data = d; iw_valid = 1'b1;
        @(posedge clk);
        #1ns;
        iw_valid = 1'b0;
        m_cap[dst] = d;
        m_tag[dst] = 1'b0;
        check_reg(dst, req);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    always @(negedge clk) begin
        if (!rst && res_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3", "unexpected result", 128'(res_cause), 128'(0));
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(res_cause == 2'(e.cause) && res_ok == (e.cause == 0), e.req,
                      "access cause/ok", {res_ok, 2'(res_cause)},
                      {(e.cause == 0), 2'(e.cause)});
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", "run timed out", 128'(0), 128'(1));
        finish_run();
    end

    initial begin
        for (int i = 0; i < NREGS; i++) begin
            m_cap[i] = '0;
            m_tag[i] = 1'b0;
        end
        m_cap[0] = mk(32'd0, 32'd0, 32'hFFFF_FFFF, 4'hF);
        m_tag[0] = 1'b1;

        repeat (3) @(posedge clk);
        #1ns;
        rst = 1'b0;

        // R2: reset state
        check(res_valid == 1'b0, "R2", "res_valid after reset", 128'(res_valid), 128'(0));
        check_reg(0, "R2");
        check_reg(3, "R2");

        // R6 / R3: root access passes, back-to-back with a write access
        do_access(0, 0, 4, "R6");
        do_access(0, 1, 8, "R3");

        // R7 / R1: monotonic derive keeps the tag, reserved bits zero
        do_derive(0, 1, 32'h1000, 32'h1000, 32'h100, 4'b0011, "R7");
        check(rd_data[127:100] == 28'd0 && rd_data[99:96] == 4'b0011, "R1",
              "field positions", rd_data, mk(32'h1000, 32'h1000, 32'h100, 4'b0011));
        do_access(1, 0, 4, "R6");
        // R5: missing execute and seal rights
        do_access(1, 2, 4, "R5");
        do_access(1, 3, 1, "R5");

        // R6: exact top passes, one byte past fails
        do_derive(1, 2, 32'h10FC, 32'h1000, 32'h100, 4'b0001, "R7");
        do_access(2, 0, 4, "R6");
        do_access(2, 0, 5, "R6");
        // R6: below base fails
        do_derive(1, 3, 32'h0FFF, 32'h1000, 32'h100, 4'b0001, "R7");
        do_access(3, 0, 1, "R6");

        // R8: non-monotonic derives lose the tag
        do_derive(1, 4, 32'h1000, 32'h0FF0, 32'h10, 4'b0001, "R8");
        do_derive(1, 5, 32'h1000, 32'h1000, 32'h101, 4'b0001, "R8");
        do_derive(1, 6, 32'h1000, 32'h1000, 32'h80, 4'b0111, "R8");
        // R4: untagged register with permissive fields reports tag fault
        do_access(4, 0, 1, "R4");
        // R8: derive from an untagged source stays untagged
        do_derive(4, 7, 32'h0FF0, 32'h0FF0, 32'h8, 4'b0001, "R8");

        // R10: ranges near 2^32 do not wrap
        do_derive(0, 5, 32'hFFFF_FFF0, 32'hFFFF_FF00, 32'hFF, 4'b0001, "R10");
        do_access(5, 0, 16, "R10");
        do_access(5, 0, 15, "R10");
        do_derive(0, 6, 32'hFFFF_FF00, 32'hFFFF_FF00, 32'h100, 4'b0001, "R10");

        // R9: integer write stores raw data with the tag cleared
        do_intw(6, {28'hABCDEF1, 4'hF, 32'hFFFF_FFFF, 32'd0, 32'd0}, "R9");
        do_access(6, 0, 4, "R9");

        // R9: integer write wins over a same-cycle derive to one register
        iw_dst = 3'd7; iw_data = 128'h1234_5678; iw_valid = 1'b1;
        drv_src = 3'd0; drv_dst = 3'd7; drv_addr = '0; drv_base = '0;
        drv_len = 32'h10; drv_perms = 4'b0001; drv_valid = 1'b1;
        @(posedge clk);
        #1ns;
        iw_valid = 1'b0; drv_valid = 1'b0;
        m_cap[7] = 128'h1234_5678;
        m_tag[7] = 1'b0;
        check_reg(7, "R9");

        // R9: overwriting the root strips its validity
        do_intw(0, mk(32'd0, 32'd0, 32'hFFFF_FFFF, 4'hF), "R9");
        do_access(0, 0, 1, "R9");

        repeat (3) @(posedge clk);
        #1ns;
        check(exp_q.size() == 0, "R3", "results outstanding",
              128'(exp_q.size()), 128'(0));
        finish_run();
    end

endmodule